// File: doc/BRIEF.md
# DMA Transfer Length Counter

This block keeps the byte count that bounds one DMA transfer of a storage bus controller. Software writes the low and middle count bytes into shadow registers. The live counter takes those values only when a command byte with its DMA bit set arrives. A transfer-information command with the DMA bit set starts a transfer. Its effective length is the smaller of the loaded count and a limit: 32 bytes while a command phase is in progress, and otherwise the number of bytes the target still has pending. A loaded count of zero stands for 65536 bytes.

Once a transfer starts, a remaining-length register counts down by the number of bytes the data path acknowledges in each cycle. When the transfer ends, the block sets terminal count and raises the interrupt line. It also clears the live count and pulses a one-cycle strobe. Neighbouring logic uses that strobe to write bus service into the interrupt register and to zero the sequence step and the FIFO flags. Memory addressing and the bus cycles themselves are outside the block; they appear only as the byte-acknowledge input.

The controller has four states:
- IDLE waits for a start.
- MOVE counts acknowledged bytes.
- HOLD is entered on a device-to-memory (read) transfer once the count reaches zero. It waits there for the target to report that it has finished.
- FINISH lasts one cycle and performs the completion.

The transitions are:
- IDLE→MOVE on an accepted start.
- MOVE→FINISH when the count reaches zero on a write, or at once on a partial-buffer report.
- MOVE→HOLD when the count reaches zero on a read.
- HOLD→FINISH on the target-done report.
- FINISH→IDLE always.

Top module: `xfer_len_counter`

## Requirements
- R1: After reset, busy, stat_tc, irq and done_pulse are 0, and live_count and remaining are 0.
- R2: live_count equals {mid byte, low byte} of the last shadow writes. It is reloaded only by a cmd_we whose cmd_byte bit 7 is 1. Shadow writes alone leave it unchanged.
- R3: A write to either count byte clears stat_tc on the next cycle, unless a completion happens in the same cycle.
- R4: A loaded count of 0 gives an effective length of 65536.
- R5: With cmd_phase high at start, the effective length is min(count, 32).
- R6: With cmd_phase low at start, the effective length is min(count, pending_len).
- R7: A start is cmd_we with cmd_byte = 0x90 (bit 7 set, low seven bits 0x10). It is accepted only when busy is low. Acceptance loads remaining with the effective length, raises busy and clears stat_tc on the next cycle.
- R8: While busy, each cycle with ack_valid lowers remaining by ack_bytes, saturating at 0. Acknowledges while idle have no effect.
- R9: Completion makes done_pulse high for exactly one cycle. On the cycle after it, busy is 0, stat_tc is 1, irq is 1 and live_count is 0.
- R10: A tgt_partial pulse during counting completes the transfer at once, leaving remaining at its current value.
- R11: On a transfer started with read_dir high, reaching zero does not complete it. Completion follows tgt_done.
- R12: A start while busy is ignored: remaining, and so the transfer, is unaffected.
- R13: intr_clr lowers irq on the next cycle, unless a completion happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_lo_we | input | 1 | Write strobe for the low count byte |
| cnt_mid_we | input | 1 | Write strobe for the middle count byte |
| cnt_wdata | input | 8 | Count byte write data |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte; bit 7 is the DMA bit |
| cmd_phase | input | 1 | Command phase in progress |
| pending_len | input | 17 | Magnitude of the bytes the target has pending |
| read_dir | input | 1 | Transfer runs from the device to memory |
| ack_valid | input | 1 | Data path acknowledges bytes this cycle |
| ack_bytes | input | 4 | Number of bytes acknowledged |
| tgt_partial | input | 1 | Target reports a partially used buffer |
| tgt_done | input | 1 | Target reports it has finished |
| intr_clr | input | 1 | Interrupt register was read |
| live_count | output | 16 | Live transfer counter |
| remaining | output | 17 | Bytes left in the current transfer |
| busy | output | 1 | Transfer in progress |
| stat_tc | output | 1 | Terminal-count status bit |
| irq | output | 1 | Interrupt request |
| done_pulse | output | 1 | One-cycle completion strobe |

## Verification
A table of starts covers several cases:
- counts below and above the pending size;
- the command-phase cap with pending at both zero and large values;
- a zero count against an even larger pending size;
- a zero count against a smaller pending size.

Together these separate the 65536 substitution from the two kinds of minimum and from the choice of limit. Directed cases then cover the following, each observed through the remaining, busy and status outputs:
- acknowledges that overshoot the remaining count;
- a partial-buffer stop;
- a read that must wait for the target;
- a start issued while busy;
- shadow writes without a reload.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MOVE,
        ST_HOLD,
        ST_FINISH
    } xlc_state_e;

    localparam logic [6:0] OP_XFER_INFO = 7'h10;
endpackage

// File: rtl/xlc_count_regs.sv
module xlc_count_regs #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic              mid_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              reload,
    input  logic              clear_live,
    output logic [CNT_W-1:0]  shadow,
    output logic [CNT_W-1:0]  live
);
    logic [BYTE_W-1:0] lo_q, mid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            mid_q <= '0;
        end else begin
            if (lo_we)  lo_q  <= wdata;
            if (mid_we) mid_q <= wdata;
        end
    end

    assign shadow = {mid_q, lo_q};

    // A reload in the completion cycle is the newer request and wins.
    always_ff @(posedge clk) begin
        if (!rst_n)          live <= '0;
        else if (reload)     live <= shadow;
        else if (clear_live) live <= '0;
    end
endmodule

// File: rtl/xlc_len_calc.sv
module xlc_len_calc #(
    parameter int CNT_W   = 16,
    parameter int CMD_CAP = 32,
    localparam int LEN_W  = CNT_W + 1
) (
    input  logic [CNT_W-1:0] count,
    input  logic             cmd_phase,
    input  logic [LEN_W-1:0] pending,
    output logic [LEN_W-1:0] eff_len
);
    localparam logic [LEN_W-1:0] CAP_LEN  = LEN_W'(CMD_CAP);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(1) << CNT_W;

    logic [LEN_W-1:0] full_cnt, limit;

    always_comb begin
        full_cnt = (count == '0) ? FULL_LEN : {1'b0, count};
        limit    = cmd_phase ? CAP_LEN : pending;
        eff_len  = (full_cnt < limit) ? full_cnt : limit;
    end
endmodule

// File: rtl/xlc_fsm.sv
module xlc_fsm
    import xlc_pkg::*;
#(
    parameter int LEN_W = 17,
    parameter int ACK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] eff_len,
    input  logic             read_dir,
    input  logic             ack_valid,
    input  logic [ACK_W-1:0] ack_bytes,
    input  logic             tgt_partial,
    input  logic             tgt_done,
    output logic [LEN_W-1:0] remaining,
    output logic             busy,
    output logic             finish
);
    xlc_state_e state_q, state_d;
    logic             rd_q;
    logic [LEN_W-1:0] rem_next;
    logic [LEN_W-1:0] ack_ext;

    assign ack_ext = LEN_W'(ack_bytes);

    always_comb begin
        rem_next = remaining;
        if (state_q == ST_MOVE && ack_valid)
            rem_next = (ack_ext >= remaining) ? '0 : remaining - ack_ext;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_MOVE;
            ST_MOVE: begin
                if (tgt_partial)        state_d = ST_FINISH;
                else if (rem_next == '0) state_d = rd_q ? ST_HOLD : ST_FINISH;
            end
            ST_HOLD:   if (tgt_done) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
            rd_q      <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            remaining <= eff_len;
            rd_q      <= read_dir;
        end else if (state_q == ST_MOVE && !tgt_partial) begin
            remaining <= rem_next;
        end
    end

    assign busy   = (state_q != ST_IDLE);
    assign finish = (state_q == ST_FINISH);
endmodule

// File: rtl/xfer_len_counter.sv
module xfer_len_counter
    import xlc_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int CMD_CAP = 32,
    parameter int ACK_W   = 4,
    localparam int CNT_W  = 2 * BYTE_W,
    localparam int LEN_W  = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_lo_we,
    input  logic              cnt_mid_we,
    input  logic [BYTE_W-1:0] cnt_wdata,
    input  logic              cmd_we,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              cmd_phase,
    input  logic [LEN_W-1:0]  pending_len,
    input  logic              read_dir,
    input  logic              ack_valid,
    input  logic [ACK_W-1:0]  ack_bytes,
    input  logic              tgt_partial,
    input  logic              tgt_done,
    input  logic              intr_clr,
    output logic [CNT_W-1:0]  live_count,
    output logic [LEN_W-1:0]  remaining,
    output logic              busy,
    output logic              stat_tc,
    output logic              irq,
    output logic              done_pulse
);
    logic             dma_cmd, start_cmd, start_ok;
    logic [CNT_W-1:0] shadow;
    logic [LEN_W-1:0] eff_len;

    assign dma_cmd   = cmd_we && cmd_byte[BYTE_W-1];
    assign start_cmd = dma_cmd && (cmd_byte[6:0] == OP_XFER_INFO);
    assign start_ok  = start_cmd && !busy;

    xlc_count_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .lo_we      (cnt_lo_we),
        .mid_we     (cnt_mid_we),
        .wdata      (cnt_wdata),
        .reload     (dma_cmd),
        .clear_live (done_pulse),
        .shadow     (shadow),
        .live       (live_count)
    );

    // The start uses the shadow value, which the same command loads live.
    xlc_len_calc #(.CNT_W(CNT_W), .CMD_CAP(CMD_CAP)) u_len (
        .count     (shadow),
        .cmd_phase (cmd_phase),
        .pending   (pending_len),
        .eff_len   (eff_len)
    );

    xlc_fsm #(.LEN_W(LEN_W), .ACK_W(ACK_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_ok),
        .eff_len     (eff_len),
        .read_dir    (read_dir),
        .ack_valid   (ack_valid),
        .ack_bytes   (ack_bytes),
        .tgt_partial (tgt_partial),
        .tgt_done    (tgt_done),
        .remaining   (remaining),
        .busy        (busy),
        .finish      (done_pulse)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_tc <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (done_pulse)                               stat_tc <= 1'b1;
            else if (cnt_lo_we || cnt_mid_we || start_ok) stat_tc <= 1'b0;
            if (done_pulse)    irq <= 1'b1;
            else if (intr_clr) irq <= 1'b0;
        end
    end
endmodule

// File: rtl/xlc_checker.sv
module xlc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cnt_lo_we,
    input logic        cnt_mid_we,
    input logic        cmd_we,
    input logic [7:0]  cmd_byte,
    input logic        ack_valid,
    input logic        intr_clr,
    input logic [15:0] live_count,
    input logic [16:0] remaining,
    input logic        busy,
    input logic        stat_tc,
    input logic        irq,
    input logic        done_pulse
);
    logic start_cmd, dma_cmd;
    assign dma_cmd   = cmd_we && cmd_byte[7];
    assign start_cmd = dma_cmd && (cmd_byte[6:0] == 7'h10);

    assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_cmd && !busy |=> busy && !stat_tc);

    assert_tc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_lo_we || cnt_mid_we) && !done_pulse |=> !stat_tc);

    assert_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && !$past(dma_cmd) |-> stat_tc && irq && (live_count == 16'd0));

    assert_one_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    assert_no_grow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> remaining <= $past(remaining));

    assert_busy_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start_cmd && !ack_valid |=> remaining == $past(remaining));

    assert_irq_clr_R13: assert property (@(posedge clk) disable iff (!rst_n)
        intr_clr && !done_pulse |=> !irq);
endmodule

bind xfer_len_counter xlc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_lo_we  (cnt_lo_we),
    .cnt_mid_we (cnt_mid_we),
    .cmd_we     (cmd_we),
    .cmd_byte   (cmd_byte),
    .ack_valid  (ack_valid),
    .intr_clr   (intr_clr),
    .live_count (live_count),
    .remaining  (remaining),
    .busy       (busy),
    .stat_tc    (stat_tc),
    .irq        (irq),
    .done_pulse (done_pulse)
);

// File: tb/xfer_len_counter_tb.sv
module xfer_len_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_lo_we = 0, cnt_mid_we = 0;
    logic [7:0]  cnt_wdata = 0;
    logic        cmd_we = 0;
    logic [7:0]  cmd_byte = 0;
    logic        cmd_phase = 0;
    logic [16:0] pending_len = 0;
    logic        read_dir = 0;
    logic        ack_valid = 0;
    logic [3:0]  ack_bytes = 0;
    logic        tgt_partial = 0, tgt_done = 0, intr_clr = 0;
    logic [15:0] live_count;
    logic [16:0] remaining;
    logic        busy, stat_tc, irq, done_pulse;

    int n_checks = 0;
    int n_fail = 0;
    int pulses = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    xfer_len_counter u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_lo_we(cnt_lo_we), .cnt_mid_we(cnt_mid_we),
        .cnt_wdata(cnt_wdata), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
        .cmd_phase(cmd_phase), .pending_len(pending_len), .read_dir(read_dir),
        .ack_valid(ack_valid), .ack_bytes(ack_bytes), .tgt_partial(tgt_partial),
        .tgt_done(tgt_done), .intr_clr(intr_clr), .live_count(live_count),
        .remaining(remaining), .busy(busy), .stat_tc(stat_tc), .irq(irq),
        .done_pulse(done_pulse)
    );

    always @(negedge clk) if (done_pulse) pulses++;

    // {cmd_phase, pending_len, count, expected effective length}
    localparam int NVEC = 7;
    localparam logic [50:0] VEC [NVEC] = '{
        {1'b0, 17'd100,     16'h0040, 17'd64},
        {1'b0, 17'd20,      16'h0100, 17'd20},
        {1'b1, 17'd500,     16'h0100, 17'd32},
        {1'b1, 17'd0,       16'h0010, 17'd16},
        {1'b0, 17'h1FFFF,   16'h0000, 17'd65536},
        {1'b0, 17'd300,     16'h0000, 17'd300},
        {1'b0, 17'd4660,    16'h0234, 17'd564}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_count(input logic [15:0] v);
        cnt_lo_we = 1; cnt_wdata = v[7:0];
        @(negedge clk);
        cnt_lo_we = 0; cnt_mid_we = 1; cnt_wdata = v[15:8];
        @(negedge clk);
        cnt_mid_we = 0;
    endtask

    task automatic wr_cmd(input logic [7:0] c);
        cmd_we = 1; cmd_byte = c;
        @(negedge clk);
        cmd_we = 0;
    endtask

    task automatic ack(input int n);
        ack_valid = 1; ack_bytes = 4'(n);
        @(negedge clk);
        ack_valid = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < 6000 && remaining != 0; i++) ack(15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !stat_tc && !irq && !done_pulse, "R1 flags", {busy, stat_tc, irq}, 0);
        check(live_count == 0 && remaining == 0, "R1 counts", live_count + remaining, 0);
        rst_n = 1;
        @(negedge clk);

        // Acks while idle have no effect
        ack(9);
        check(remaining == 0 && !busy, "R8 idle ack", remaining, 0);

        for (int v = 0; v < NVEC; v++) begin
            logic [16:0] exp_len;
            logic [15:0] cnt;
            exp_len = VEC[v][16:0];
            cnt = VEC[v][32:17];
            pending_len = VEC[v][49:33];
            cmd_phase = VEC[v][50];
            wr_count(cnt);
            pulses = 0;
            wr_cmd(8'h90);
            cmd_phase = 0;
            // R4 R5 R6 effective length, R7 start
            check(remaining == exp_len, "R4/R5/R6 length", remaining, exp_len);
            check(busy && !stat_tc, "R7 start", {busy, stat_tc}, 2);
            check(live_count == cnt, "R2 reload", live_count, cnt);
            drain();
            @(negedge clk);
            check(!busy && stat_tc && irq && live_count == 0, "R9 completion",
                  {busy, stat_tc, irq}, 3);
            check(pulses == 1, "R9 pulse", pulses, 1);
            intr_clr = 1; @(negedge clk); intr_clr = 0;
            check(!irq, "R13 clear", irq, 0);
        end

        // R3: count write clears terminal count
        check(stat_tc, "R3 pre", stat_tc, 1);
        cnt_lo_we = 1; cnt_wdata = 8'h34; @(negedge clk); cnt_lo_we = 0;
        check(!stat_tc, "R3 clear", stat_tc, 0);
        // R2: shadow writes alone leave live unchanged
        cnt_mid_we = 1; cnt_wdata = 8'h12; @(negedge clk); cnt_mid_we = 0;
        check(live_count == 0, "R2 no reload", live_count, 0);
        wr_cmd(8'h80);
        check(live_count == 16'h1234 && !busy, "R2 dma reload", live_count, 16'h1234);

        // R12 start while busy ignored, R8 saturation
        pending_len = 17'd100;
        wr_count(16'd50);
        wr_cmd(8'h90);
        ack(10);
        check(remaining == 40, "R8 decrement", remaining, 40);
        wr_count(16'd5);
        wr_cmd(8'h90);
        check(remaining == 40 && busy, "R12 ignored", remaining, 40);
        ack(15); ack(15);
        check(remaining == 10, "R8 step", remaining, 10);
        ack(15);
        check(remaining == 0, "R8 saturate", remaining, 0);
        @(negedge clk);
        check(!busy && stat_tc, "R8 end", {busy, stat_tc}, 1);

        // R10 partial buffer
        wr_count(16'd40);
        wr_cmd(8'h90);
        ack(5);
        tgt_partial = 1; @(negedge clk); tgt_partial = 0;
        check(busy && done_pulse, "R10 finish state", {busy, done_pulse}, 3);
        @(negedge clk);
        check(!busy && stat_tc && remaining == 35, "R10 partial", remaining, 35);

        // R11 read waits for target
        pending_len = 17'd8;
        read_dir = 1;
        wr_count(16'd8);
        wr_cmd(8'h90);
        read_dir = 0;
        ack(8);
        repeat (3) @(negedge clk);
        check(busy && !stat_tc && remaining == 0, "R11 hold", {busy, stat_tc}, 2);
        tgt_done = 1; @(negedge clk); tgt_done = 0;
        @(negedge clk);
        check(!busy && stat_tc && irq, "R11 done", {busy, stat_tc, irq}, 3);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule